// File: doc/BRIEF.md
# Cascadable Dual Accumulation Decimation Filter

This block cuts the rate at which conversion results from a four-channel converter have to be collected. It holds two filter stages. Each stage picks one of the four channel result inputs, adds a programmable number N of consecutive accepted samples into a running sum, and then moves the total into its final result register. In the same step the running sum is cleared, so the next group starts from zero. Each final store can raise a one-cycle service request, so that a bus master is called once per N conversions and not once per conversion.

The second stage can be chained behind the first. In chained mode it accumulates the first stage's final results, which gives a two-level decimator with a total ratio of N0 times N1. A suspend input stops the intake of new channel samples and freezes all state. A first-stage result that was already produced is still taken up by a chained second stage.

Configuration uses one write port. A select bit addresses one stage's 8-bit configuration word. A write that changes how samples are collected restarts that stage's running sum.

Top module: `acc_decim_filter`

## Requirements
- R1: After reset both results read 0, both service requests are low, and each stage is set to source channel 0, N = 1, request disabled and unchained. With that setting a single channel-0 sample appears unchanged on res0_o one cycle later, with no request.
- R2: A stage takes samples only from the channel named by bits [1:0] of its configuration word. The valid strobes of the other channels have no effect on its sum.
- R3: Bits [5:2] hold N-1, so N runs from 1 to 16. A sample is accepted on a clock where the selected channel's valid is high. The cycle after the Nth accepted sample, the result output shows the sum of those N samples. The next group then starts from zero, and the result does not change between stores.
- R4: Bit 6 enables the stage's service request. When it is set, the request is high for exactly the cycle in which the new result first appears. When it is clear, the result still updates but no request is raised.
- R5: Bit 7 of the second stage's word (select 1) chains it. It then accumulates each first-stage result once, accepting it in the cycle after that result appears, into an 18-bit sum. Its own channel select is ignored.
- R6: Bit 7 of the first stage's word (select 0) suppresses the first stage's service request, but only while the second stage is chained. The first stage's results are unaffected.
- R7: A write that changes a stage's source or N, or the second stage's chain bit, clears that stage's running sum and sample count. A sample offered in the write cycle is discarded. A write that leaves those fields unchanged keeps the partial sum.
- R8: While suspend_i is high, no channel sample is accepted, and results and requests stay unchanged. A first-stage result produced in the cycle before suspend rose is still accepted by a chained second stage.
- R9: Sums cannot overflow. Sixteen samples of 1023 give 16368 on res0_o, and 16 chained results of 16368 give 261888 on res1_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_data_i | input | 40 | Four 10-bit channel results, channel k at bits [10k+9:10k] |
| ch_vld_i | input | 4 | Per-channel result valid strobe |
| suspend_i | input | 1 | Freeze request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_blk_i | input | 1 | Stage addressed by the write (0 first, 1 second) |
| cfg_data_i | input | 8 | Configuration word: [1:0] source, [5:2] N-1, [6] request enable, [7] suppress (stage 0) or chain (stage 1) |
| res0_o | output | 14 | First-stage final result |
| res1_o | output | 18 | Second-stage final result |
| srq0_o | output | 1 | First-stage service request pulse |
| srq1_o | output | 1 | Second-stage service request pulse |

## Verification
Two collisions matter most. The first is a configuration write that lands in the same cycle as an accepted sample of the stage it restarts. The second is a first-stage store forwarded into a chained second stage in the very cycle that suspend rises. The first is provoked by issuing the write while a selected channel's valid is high; the restarted group must then sum only the later samples. The second is provoked by raising suspend just after a first-stage store; the second-stage total must include the value produced before the freeze. Both cases are also compared every clock against a behavioural model.

// File: rtl/afd_pkg.sv
package afd_pkg;

   localparam int unsigned PKG_SRC_W = 2;
   localparam int unsigned PKG_CNT_W = 4;
   localparam int unsigned PKG_BLK_N = 2;

   // configuration word of one stage, msb first
   typedef struct packed {
      logic                 mode;    // stage 0: suppress request when chained, stage 1: chain
      logic                 srq_en;
      logic [PKG_CNT_W-1:0] cnt_m1;
      logic [PKG_SRC_W-1:0] src;
   } afd_cfg_t;

   localparam int unsigned PKG_CFG_W = $bits(afd_cfg_t);

endpackage

// File: rtl/afd_src_mux.sv
module afd_src_mux #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DATA_W = 10,
   parameter int unsigned SEL_W  = 2
) (
   input  logic [SEL_W-1:0]         sel_i,
   input  logic [NUM_CH*DATA_W-1:0] data_i,
   input  logic [NUM_CH-1:0]        vld_i,
   output logic [DATA_W-1:0]        data_o,
   output logic                     vld_o
);

   if (NUM_CH != (1 << SEL_W)) begin : g_bad_sel
      $error("afd_src_mux: NUM_CH must equal 2**SEL_W");
   end

   logic [DATA_W-1:0] lane [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      assign lane[c] = data_i[c*DATA_W +: DATA_W];
   end

   assign data_o = lane[sel_i];
   assign vld_o  = vld_i[sel_i];

endmodule

// File: rtl/afd_cfg_regs.sv
module afd_cfg_regs
   import afd_pkg::*;
(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we_i,
   input  logic                           blk_i,
   input  afd_cfg_t                       wdata_i,
   output afd_cfg_t [PKG_BLK_N-1:0]       cfg_o,
   output logic     [PKG_BLK_N-1:0]       clr_o
);

   localparam int unsigned CHAIN_BLK = PKG_BLK_N - 1;

   for (genvar b = 0; b < PKG_BLK_N; b++) begin : g_blk
      afd_cfg_t word_q;
      logic     hit;
      logic     mode_sens;

      assign hit       = we_i && (int'(blk_i) == b);
      // only the chainable stage restarts when its mode bit changes
      assign mode_sens = (b == CHAIN_BLK) && (wdata_i.mode != word_q.mode);
      assign clr_o[b]  = hit && ((wdata_i.src != word_q.src) ||
                                 (wdata_i.cnt_m1 != word_q.cnt_m1) ||
                                 mode_sens);
      assign cfg_o[b]  = word_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (hit) begin
            word_q <= wdata_i;
         end
      end
   end

endmodule

// File: rtl/afd_stage.sv
module afd_stage #(
   parameter int unsigned IN_W  = 14,
   parameter int unsigned ACC_W = 18,
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             in_vld_i,
   input  logic [IN_W-1:0]  in_data_i,
   input  logic [CNT_W-1:0] count_m1_i,
   input  logic             srq_en_i,
   output logic [ACC_W-1:0] res_o,
   output logic             store_o,
   output logic             srq_o
);

   if (ACC_W < IN_W + CNT_W) begin : g_bad_acc
      $error("afd_stage: ACC_W too small for 2**CNT_W samples");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] res_q;
   logic [CNT_W-1:0] cnt_q;
   logic             store_q;
   logic             srq_q;
   logic [ACC_W-1:0] sum;
   logic             last;

   assign sum  = acc_q + ACC_W'(in_data_i);
   assign last = (cnt_q == count_m1_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         res_q   <= '0;
         cnt_q   <= '0;
         store_q <= 1'b0;
         srq_q   <= 1'b0;
      end else begin
         store_q <= 1'b0;
         srq_q   <= 1'b0;
         if (clr_i) begin
            // restart wins over a sample in the same cycle
            acc_q <= '0;
            cnt_q <= '0;
         end else if (in_vld_i) begin
            if (last) begin
               res_q   <= sum;
               acc_q   <= '0;
               cnt_q   <= '0;
               store_q <= 1'b1;
               srq_q   <= srq_en_i;
            end else begin
               acc_q <= sum;
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   assign res_o   = res_q;
   assign store_o = store_q;
   assign srq_o   = srq_q;

endmodule

// File: rtl/acc_decim_filter.sv
module acc_decim_filter
   import afd_pkg::*;
#(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned SAMPLE_W = 10,
   parameter int unsigned MAX_N    = 16,
   parameter bit          CHAIN_EN = 1'b1,
   localparam int unsigned SEL_W   = $clog2(NUM_CH),
   localparam int unsigned CNT_W   = $clog2(MAX_N),
   localparam int unsigned RES0_W  = SAMPLE_W + CNT_W,
   localparam int unsigned RES1_W  = RES0_W + CNT_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CH*SAMPLE_W-1:0] ch_data_i,
   input  logic [NUM_CH-1:0]          ch_vld_i,
   input  logic                       suspend_i,
   input  logic                       cfg_we_i,
   input  logic                       cfg_blk_i,
   input  logic [PKG_CFG_W-1:0]       cfg_data_i,
   output logic [RES0_W-1:0]          res0_o,
   output logic [RES1_W-1:0]          res1_o,
   output logic                       srq0_o,
   output logic                       srq1_o
);

   if (SEL_W != PKG_SRC_W) begin : g_bad_src
      $error("acc_decim_filter: NUM_CH does not match the source field width");
   end
   if (CNT_W != PKG_CNT_W || MAX_N != (1 << CNT_W)) begin : g_bad_cnt
      $error("acc_decim_filter: MAX_N must be 2**PKG_CNT_W");
   end

   afd_cfg_t [PKG_BLK_N-1:0] cfg_q;
   logic     [PKG_BLK_N-1:0] clr;
   afd_cfg_t                 cfg_wr;

   assign cfg_wr = afd_cfg_t'(cfg_data_i);

   afd_cfg_regs u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we_i),
      .blk_i   (cfg_blk_i),
      .wdata_i (cfg_wr),
      .cfg_o   (cfg_q),
      .clr_o   (clr)
   );

   logic [SAMPLE_W-1:0]  mx_data [PKG_BLK_N];
   logic [PKG_BLK_N-1:0] mx_vld;

   for (genvar b = 0; b < PKG_BLK_N; b++) begin : g_mux
      afd_src_mux #(
         .NUM_CH (NUM_CH),
         .DATA_W (SAMPLE_W),
         .SEL_W  (SEL_W)
      ) u_mux (
         .sel_i  (cfg_q[b].src),
         .data_i (ch_data_i),
         .vld_i  (ch_vld_i),
         .data_o (mx_data[b]),
         .vld_o  (mx_vld[b])
      );
   end

   logic              chain_on;
   logic              st0_store;
   logic              st1_store;
   logic [RES0_W-1:0] res0;
   logic              s0_vld;
   logic              s0_srq_en;
   logic              s1_vld;
   logic [RES0_W-1:0] s1_data;

   assign s0_vld    = mx_vld[0] & ~suspend_i;
   assign s0_srq_en = cfg_q[0].srq_en & ~(chain_on & cfg_q[0].mode);

   afd_stage #(
      .IN_W  (SAMPLE_W),
      .ACC_W (RES0_W),
      .CNT_W (CNT_W)
   ) u_stage0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr[0]),
      .in_vld_i   (s0_vld),
      .in_data_i  (mx_data[0]),
      .count_m1_i (cfg_q[0].cnt_m1),
      .srq_en_i   (s0_srq_en),
      .res_o      (res0),
      .store_o    (st0_store),
      .srq_o      (srq0_o)
   );

   if (CHAIN_EN) begin : g_chain
      assign chain_on = cfg_q[1].mode;
      // a stored first-stage result is already accepted: suspend does not gate it
      assign s1_vld   = chain_on ? st0_store : (mx_vld[1] & ~suspend_i);
      assign s1_data  = chain_on ? res0 : RES0_W'(mx_data[1]);
   end else begin : g_flat
      assign chain_on = 1'b0;
      assign s1_vld   = mx_vld[1] & ~suspend_i;
      assign s1_data  = RES0_W'(mx_data[1]);
   end

   afd_stage #(
      .IN_W  (RES0_W),
      .ACC_W (RES1_W),
      .CNT_W (CNT_W)
   ) u_stage1 (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr[1]),
      .in_vld_i   (s1_vld),
      .in_data_i  (s1_data),
      .count_m1_i (cfg_q[1].cnt_m1),
      .srq_en_i   (cfg_q[1].srq_en),
      .res_o      (res1_o),
      .store_o    (st1_store),
      .srq_o      (srq1_o)
   );

   assign res0_o = res0;

endmodule

// File: rtl/afd_checker.sv
module afd_checker
   import afd_pkg::*;
#(
   parameter int unsigned RES0_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              suspend_i,
   input logic [RES0_W-1:0] res0_o,
   input logic              srq0_o,
   input logic              srq1_o,
   input afd_cfg_t          cfg0_i,
   input afd_cfg_t          cfg1_i,
   input logic              clr0_i
);

   // R8: no first-stage intake while suspended
   a_r8_res0_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_i |=> $stable(res0_o));

   // R8: no first-stage request follows a suspended cycle
   a_r8_srq0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_i |=> !srq0_o);

   // R8: after two suspended cycles even the chained stage is still
   a_r8_srq1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (suspend_i && $past(suspend_i)) |=> !srq1_o);

   // R4: a request needs the enable that was in force at the store
   a_r4_srq1_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      srq1_o |-> $past(cfg1_i.srq_en));

   a_r4_srq0_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      srq0_o |-> $past(cfg0_i.srq_en));

   // R6: suppressed first-stage request while chained
   a_r6_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
      srq0_o |-> !($past(cfg1_i.mode) && $past(cfg0_i.mode)));

   // R7: a restart cycle never completes a group
   a_r7_restart_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      clr0_i |=> !srq0_o);

endmodule

bind acc_decim_filter afd_checker #(
   .RES0_W (RES0_W)
) u_afd_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .suspend_i (suspend_i),
   .res0_o    (res0_o),
   .srq0_o    (srq0_o),
   .srq1_o    (srq1_o),
   .cfg0_i    (cfg_q[0]),
   .cfg1_i    (cfg_q[1]),
   .clr0_i    (clr[0])
);

// File: tb/tb_acc_decim_filter.sv
module tb_acc_decim_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [39:0] ch_data = '0;
   logic [3:0]  ch_vld = '0;
   logic        suspend = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_blk = 1'b0;
   logic [7:0]  cfg_data = '0;
   logic [13:0] res0;
   logic [17:0] res1;
   logic        srq0, srq1;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;

   always #4 clk = ~clk;

   acc_decim_filter dut (
      .clk(clk), .rst_n(rst_n), .ch_data_i(ch_data), .ch_vld_i(ch_vld),
      .suspend_i(suspend), .cfg_we_i(cfg_we), .cfg_blk_i(cfg_blk),
      .cfg_data_i(cfg_data), .res0_o(res0), .res1_o(res1),
      .srq0_o(srq0), .srq1_o(srq1)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // behavioural reference: per-stage settings and running state
   int m_src[2], m_cm1[2], m_en[2], m_mode[2];
   int m_acc[2], m_cnt[2], m_res[2], m_srq[2];
   int m_st0;
   int p_st0, p_res0, ws, wc, we_en, wm, dat, vld;
   bit clr0, clr1;

   function automatic void model_stage(input int b, input bit clr, input int v, input int d);
      m_srq[b] = 0;
      if (b == 0) m_st0 = 0;
      if (clr) begin
         m_acc[b] = 0;
         m_cnt[b] = 0;
      end else if (v != 0) begin
         if (m_cnt[b] == m_cm1[b]) begin
            m_res[b] = m_acc[b] + d;
            m_acc[b] = 0;
            m_cnt[b] = 0;
            if (b == 0) begin
               m_st0 = 1;
               m_srq[0] = (m_en[0] != 0 && !(m_mode[1] != 0 && m_mode[0] != 0)) ? 1 : 0;
            end else begin
               m_srq[1] = m_en[1];
            end
         end else begin
            m_acc[b] = m_acc[b] + d;
            m_cnt[b] = m_cnt[b] + 1;
         end
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++) begin
            m_src[b] = 0; m_cm1[b] = 0; m_en[b] = 0; m_mode[b] = 0;
            m_acc[b] = 0; m_cnt[b] = 0; m_res[b] = 0; m_srq[b] = 0;
         end
         m_st0 = 0;
      end else begin
         ws = int'(cfg_data[1:0]);
         wc = int'(cfg_data[5:2]);
         we_en = int'(cfg_data[6]);
         wm = int'(cfg_data[7]);
         clr0 = cfg_we && !cfg_blk && (ws != m_src[0] || wc != m_cm1[0]);
         clr1 = cfg_we && cfg_blk && (ws != m_src[1] || wc != m_cm1[1] || wm != m_mode[1]);
         p_st0 = m_st0;
         p_res0 = m_res[0];
         vld = (ch_vld[m_src[0]] && !suspend) ? 1 : 0;
         dat = int'(ch_data[m_src[0]*10 +: 10]);
         model_stage(0, clr0, vld, dat);
         if (m_mode[1] != 0) begin
            vld = p_st0;
            dat = p_res0;
         end else begin
            vld = (ch_vld[m_src[1]] && !suspend) ? 1 : 0;
            dat = int'(ch_data[m_src[1]*10 +: 10]);
         end
         model_stage(1, clr1, vld, dat);
         if (cfg_we) begin
            m_src[cfg_blk] = ws; m_cm1[cfg_blk] = wc;
            m_en[cfg_blk] = we_en; m_mode[cfg_blk] = wm;
         end
      end
   end

   // every-clock comparison against the model, away from the edge
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         chk(res0 === 14'(m_res[0]), "R3 res0 model", res0, m_res[0]);
         chk(res1 === 18'(m_res[1]), "R3 res1 model", res1, m_res[1]);
         chk(srq0 === 1'(m_srq[0]), "R4 srq0 model", srq0, m_srq[0]);
         chk(srq1 === 1'(m_srq[1]), "R4 srq1 model", srq1, m_srq[1]);
      end
   end

   task automatic step(input logic [3:0] v, input int d0, input int d1, input int d2,
                       input int d3, input logic susp, input logic we, input logic blk,
                       input logic [7:0] wd);
      ch_vld = v;
      ch_data = {10'(d3), 10'(d2), 10'(d1), 10'(d0)};
      suspend = susp;
      cfg_we = we;
      cfg_blk = blk;
      cfg_data = wd;
      @(negedge clk);
      ch_vld = '0;
      suspend = 1'b0;
      cfg_we = 1'b0;
   endtask

   task automatic push(input int ch, input int val);
      int d[4];
      d = '{0, 0, 0, 0};
      d[ch] = val;
      step(4'(1 << ch), d[0], d[1], d[2], d[3], 1'b0, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic wr(input logic blk, input logic [7:0] wd);
      step(4'b0000, 0, 0, 0, 0, 1'b0, 1'b1, blk, wd);
   endtask

   int srq0_seen;

   initial begin
      repeat (3) @(negedge clk);
      chk(res0 === 14'd0, "R1 res0 reset", res0, 0);
      chk(res1 === 18'd0, "R1 res1 reset", res1, 0);
      chk(srq0 === 1'b0 && srq1 === 1'b0, "R1 requests reset", {srq1, srq0}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;

      // R1: default N=1 from channel 0, no request
      push(0, 7);
      chk(res0 === 14'd7, "R1 default pass", res0, 7);
      chk(srq0 === 1'b0, "R1 default no request", srq0, 0);

      // R2/R3: source 2, N=4, request enabled; all channels strobing
      wr(1'b0, 8'h4E);
      for (int i = 1; i <= 4; i++) begin
         step(4'b1111, 500, 600, 10 * i, 700, 1'b0, 1'b0, 1'b0, 8'h00);
         if (i == 2) chk(res0 === 14'd7, "R3 no early store", res0, 7);
      end
      chk(res0 === 14'd100, "R3 four-sample sum", res0, 100);
      chk(srq0 === 1'b1, "R4 request with store", srq0, 1);
      @(negedge clk);
      chk(srq0 === 1'b0, "R4 request one cycle", srq0, 0);
      for (int i = 0; i < 4; i++) step(4'b1011, 900, 901, 999, 903, 1'b0, 1'b0, 1'b0, 8'h00);
      chk(res0 === 14'd100, "R2 other channels ignored", res0, 100);
      for (int i = 0; i < 4; i++) push(2, 1);
      chk(res0 === 14'd4, "R3 fresh group", res0, 4);

      // R4: request disabled, N=2
      wr(1'b0, 8'h06);
      push(2, 5);
      push(2, 7);
      chk(res0 === 14'd12, "R4 store without request", res0, 12);
      chk(srq0 === 1'b0, "R4 disabled request", srq0, 0);

      // R7: restart in the same cycle as a sample
      wr(1'b0, 8'h49);
      push(1, 100);
      push(1, 200);
      step(4'b0010, 0, 999, 0, 0, 1'b0, 1'b1, 1'b0, 8'h4D);
      for (int i = 1; i <= 4; i++) push(1, i);
      chk(res0 === 14'd10, "R7 restart discards", res0, 10);
      push(1, 1);
      push(1, 2);
      wr(1'b0, 8'h0D);
      push(1, 3);
      push(1, 4);
      chk(res0 === 14'd10, "R7 same fields keep sum", res0, 10);

      // R9: full-scale first stage
      wr(1'b0, 8'h7C);
      for (int i = 0; i < 16; i++) push(0, 1023);
      chk(res0 === 14'd16368, "R9 stage0 full scale", res0, 16368);

      // R5/R6/R9: chained 16x16 at full scale, first request suppressed
      wr(1'b1, 8'hFC);
      wr(1'b0, 8'hFC);
      srq0_seen = 0;
      for (int i = 0; i < 256; i++) begin
         push(0, 1023);
         if (srq0 === 1'b1) srq0_seen++;
      end
      chk(res1 === 18'd1023, "R5 chain latency", res1, 1023);
      @(negedge clk);
      chk(res1 === 18'd261888, "R5 R9 chained sum", res1, 261888);
      chk(srq1 === 1'b1, "R5 chained request", srq1, 1);
      chk(srq0_seen == 0, "R6 suppressed while chained", srq0_seen, 0);
      chk(res0 === 14'd16368, "R6 results unaffected", res0, 16368);

      // R8: suspend right after a first-stage store
      wr(1'b0, 8'hC0);
      wr(1'b1, 8'hC4);
      push(0, 5);
      chk(res0 === 14'd5, "R8 pre-suspend store", res0, 5);
      for (int i = 0; i < 4; i++) begin
         step(4'b0001, 9, 0, 0, 0, 1'b1, 1'b0, 1'b0, 8'h00);
         chk(res0 === 14'd5, "R8 frozen during suspend", res0, 5);
         chk(srq1 === 1'b0, "R8 no request during suspend", srq1, 0);
      end
      push(0, 7);
      chk(res0 === 14'd7, "R8 resumes", res0, 7);
      @(negedge clk);
      chk(res1 === 18'd12, "R8 forwarded during suspend", res1, 12);

      // R6: suppress bit has no effect when unchained
      wr(1'b1, 8'h00);
      push(0, 3);
      chk(srq0 === 1'b1, "R6 request when unchained", srq0, 1);

      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual 1 expected 0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule